// File: doc/BRIEF.md
# RTC Status and Write-Permission Flag Controller

This block holds the status and flag logic that sits behind the register interface of a real-time clock. It is reached over a simple peripheral bus. It reports four things. The first is whether the calendar has been set up, based on a non-zero year. The second is whether a sub-second shift request is still being applied. The third is whether the wakeup timer and the two alarm configurations may be rewritten, which becomes true only once their enables have been cleared. The fourth is a set of sticky event flags that hardware raises and software clears.

Software clears an event by writing zero to its bit. The flag then drops a fixed number of bus cycles later. A key sequence guards the control fields. The event-flag byte of the status word stays writable without that key. An initialisation-mode bit holds both alarm write-permission flags low while it is set.

Top module: `rtc_flag_ctrl`

## Requirements
- R1: Status bit 4 reads 1 whenever `year_val` is non-zero and 0 while it is zero.
- R2: An accepted write to the shift register (offset 0xC) sets status bit 3 after that bus edge. Bit 3 stays set for 3 cycles in total, `shift_strobe` is high in the last of them, and `shift_amt` holds the written value.
- R3: Bus writes to status bit 3 have no effect on it, whether they write 1 or 0.
- R4: The wakeup write flag (status bit 2) rises 2 cycles after control bit 2 (wakeup enable) is cleared, and falls one cycle after that enable is set.
- R5: The alarm A and alarm B write flags (status bits 0 and 1) follow control bits 0 and 1 with the same timing as R4.
- R6: While status bit 7 (initialisation mode) is 1, both alarm write flags read 0 from the next cycle on; the wakeup write flag is unaffected.
- R7: The event flags (status bits 11:8, also on `evt_flags`) are set by `evt_set`. A bus write of 0 to a flag clears it 2 cycles after the write edge. Writing 1 has no effect.
- R8: While locked, writes to the control register, to status bit 7 and to the shift register are ignored. Status bits 13:8 remain writable. While unlocked, these writes take effect.
- R9: Writing 0xCA and then 0x53 to the key register (offset 0x8), with no other bus write in between, unlocks the block (status bit 5 reads 1). Any other key value relocks it.
- R10: After reset all status bits, the control register and `evt_flags` read 0. The three write flags rise 2 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Peripheral select |
| bus_enable | input | 1 | Access phase strobe |
| bus_write | input | 1 | 1 = write access |
| bus_addr | input | 4 | Byte offset: 0x0 control, 0x4 status, 0x8 key, 0xC shift |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, decoded from `bus_addr` |
| year_val | input | YEAR_W | Current calendar year field |
| evt_set | input | N_EVT | Hardware event set pulses (alarm A, alarm B, wakeup, timestamp) |
| alarm_a_en | output | 1 | Alarm A enable (control bit 0) |
| alarm_b_en | output | 1 | Alarm B enable (control bit 1) |
| wakeup_en | output | 1 | Wakeup timer enable (control bit 2) |
| init_mode | output | 1 | Initialisation mode (status bit 7) |
| evt_flags | output | N_EVT | Event flags |
| shift_strobe | output | 1 | High in the cycle the shift is applied |
| shift_amt | output | SHIFT_W | Captured shift amount |

## Verification
The bench samples each write flag in every cycle after an enable edge. A synchroniser that is one stage short or one stage long would raise the flag a cycle early or late. The event-flag clear is sampled in the two cycles after the write and in the cycle it drops, which catches a clear that happens at once or one that waits too long. The key tests break the sequence with an unrelated write and with a wrong value. The locked-state tests show that event bits can still be cleared while the control fields are refused, so a gate that also blocked bits 13:8, or blocked nothing, would fail. Initialisation mode is checked to drop only the alarm flags, so a design that forced the wakeup flag low as well would also fail.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
   localparam int unsigned REG_AW = 4;

   localparam logic [REG_AW-1:0] OFS_CTRL  = 4'h0;
   localparam logic [REG_AW-1:0] OFS_STAT  = 4'h4;
   localparam logic [REG_AW-1:0] OFS_KEY   = 4'h8;
   localparam logic [REG_AW-1:0] OFS_SHIFT = 4'hC;

   // status word bit positions
   localparam int unsigned ST_SHIFT_PEND = 3;
   localparam int unsigned ST_CAL_OK     = 4;
   localparam int unsigned ST_UNLOCKED   = 5;
   localparam int unsigned ST_INIT       = 7;
   localparam int unsigned ST_EVT_LO     = 8;
   localparam int unsigned ST_FREE_HI    = 13;

   localparam int unsigned N_WFLAG = 3;

   localparam logic [7:0] KEY_FIRST  = 8'hCA;
   localparam logic [7:0] KEY_SECOND = 8'h53;

   typedef enum logic [1:0] {
      PROT_LOCKED = 2'd0,
      PROT_HALF   = 2'd1,
      PROT_OPEN   = 2'd2
   } prot_state_e;
endpackage

// File: rtl/rtc_wprot.sv
module rtc_wprot
   import rtc_flag_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_wr,
   input  logic       other_wr,
   input  logic [7:0] key_data,
   output logic       unlocked
);
   prot_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (key_wr) begin
         if (key_data == KEY_FIRST)
            state_d = PROT_HALF;
         else if (state_q == PROT_HALF && key_data == KEY_SECOND)
            state_d = PROT_OPEN;
         else
            state_d = PROT_LOCKED;
      end else if (other_wr && state_q == PROT_HALF) begin
         state_d = PROT_LOCKED;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PROT_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == PROT_OPEN);

   // R9: unlocking only ever follows a second-key write
   assert_unlock_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(key_wr && key_data == KEY_SECOND));

   // R9: a wrong key always relocks
   assert_relock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_data != KEY_FIRST && key_data != KEY_SECOND) |=> !unlocked);
endmodule

// File: rtl/rtc_wflag_sync.sv
module rtc_wflag_sync #(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          FORCE_IN_INIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic init_i,
   output logic wf_o
);
   localparam int unsigned PIPE = SYNC_STAGES - 1;

   initial assert (SYNC_STAGES >= 2) else $fatal(1, "SYNC_STAGES must be at least 2");

   logic [PIPE-1:0] pipe_q;
   logic            block;
   logic            wf_q;

   generate
      if (PIPE == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q[0] <= ~en_i;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    pipe_q <= '0;
            else if (en_i) pipe_q <= '0;
            else           pipe_q <= {pipe_q[PIPE-2:0], 1'b1};
         end
      end

      if (FORCE_IN_INIT) begin : g_force
         assign block = init_i;
         // R6: initialisation mode drops the flag on the next cycle
         assert_init_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            init_i |=> !wf_o);
      end else begin : g_free
         assign block = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wf_q <= 1'b0;
      else        wf_q <= pipe_q[PIPE-1] & ~en_i & ~block;
   end

   assign wf_o = wf_q;

   // R4: setting the enable removes permission one cycle later
   assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |=> !wf_o);

   // R5: permission only appears while the enable was clear
   assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wf_o) |-> $past(!en_i));
endmodule

// File: rtl/rtc_evt_flag.sv
module rtc_evt_flag #(
   parameter int unsigned CLR_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_wr_i,
   output logic flag_o
);
   initial assert (CLR_LAT >= 1) else $fatal(1, "CLR_LAT must be at least 1");

   logic [CLR_LAT-1:0] clr_pipe_q;
   logic               flag_q;

   generate
      if (CLR_LAT == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clr_pipe_q <= '0;
            else        clr_pipe_q[0] <= clr_wr_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clr_pipe_q <= '0;
            else        clr_pipe_q <= {clr_pipe_q[CLR_LAT-2:0], clr_wr_i};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       flag_q <= 1'b0;
      else if (set_i)                   flag_q <= 1'b1;
      else if (clr_pipe_q[CLR_LAT-1])   flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R7: a hardware event always lands
   assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

   // R7: the flag never rises without an event
   assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/rtc_shift_ctl.sv
module rtc_shift_ctl #(
   parameter int unsigned LAT   = 3,
   parameter int unsigned AMT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [AMT_W-1:0] amt_i,
   output logic             pending_o,
   output logic             strobe_o,
   output logic [AMT_W-1:0] amt_o
);
   localparam int unsigned CW = (LAT > 2) ? $clog2(LAT) : 1;

   initial assert (LAT >= 2) else $fatal(1, "LAT must be at least 2");

   logic             pend_q;
   logic [CW-1:0]    cnt_q;
   logic [AMT_W-1:0] amt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
         amt_q  <= '0;
      end else if (req_i && !pend_q) begin
         pend_q <= 1'b1;
         cnt_q  <= CW'(LAT - 1);
         amt_q  <= amt_i;
      end else if (pend_q) begin
         if (cnt_q == '0) pend_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign pending_o = pend_q;
   assign strobe_o  = pend_q && (cnt_q == '0);
   assign amt_o     = amt_q;

   // R2: an accepted request is pending after the edge
   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !pending_o) |=> pending_o);

   // R2: the application strobe ends the pending state
   assert_finish_R2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !pending_o);

   // R2: a request during a pending shift leaves the amount untouched
   assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && pending_o) |=> $stable(amt_o));
endmodule

// File: rtl/rtc_flag_ctrl.sv
module rtc_flag_ctrl
   import rtc_flag_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned YEAR_W      = 8,
   parameter int unsigned SHIFT_W     = 15,
   parameter int unsigned N_EVT       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CLR_LAT     = 2,
   parameter int unsigned SHIFT_LAT   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_enable,
   input  logic               bus_write,
   input  logic [REG_AW-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [YEAR_W-1:0]  year_val,
   input  logic [N_EVT-1:0]   evt_set,
   output logic               alarm_a_en,
   output logic               alarm_b_en,
   output logic               wakeup_en,
   output logic               init_mode,
   output logic [N_EVT-1:0]   evt_flags,
   output logic               shift_strobe,
   output logic [SHIFT_W-1:0] shift_amt
);
   localparam int unsigned ST_W = 16;

   initial begin
      assert (DATA_W >= ST_W) else $fatal(1, "DATA_W too narrow");
      assert (SHIFT_W <= DATA_W) else $fatal(1, "SHIFT_W exceeds DATA_W");
      assert (N_EVT >= 1 && N_EVT <= ST_FREE_HI - ST_EVT_LO + 1)
         else $fatal(1, "N_EVT out of range");
   end

   logic               wr, wr_ctrl, wr_stat, wr_key, wr_shift;
   logic               unlocked;
   logic [N_WFLAG-1:0] ctrl_en_q;
   logic               init_q;
   logic [N_WFLAG-1:0] wflag;
   logic               shift_pending;
   logic [ST_W-1:0]    rd_stat;
   logic               unused_wdata;

   assign wr       = bus_sel && bus_enable && bus_write;
   assign wr_ctrl  = wr && (bus_addr == OFS_CTRL);
   assign wr_stat  = wr && (bus_addr == OFS_STAT);
   assign wr_key   = wr && (bus_addr == OFS_KEY);
   assign wr_shift = wr && (bus_addr == OFS_SHIFT);
   assign unused_wdata = ^bus_wdata;

   rtc_wprot u_prot (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (wr_key),
      .other_wr (wr && !wr_key),
      .key_data (bus_wdata[7:0]),
      .unlocked (unlocked)
   );

   // protected control fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en_q <= '0;
         init_q    <= 1'b0;
      end else begin
         if (wr_ctrl && unlocked) ctrl_en_q <= bus_wdata[N_WFLAG-1:0];
         if (wr_stat && unlocked) init_q    <= bus_wdata[ST_INIT];
      end
   end

   generate
      for (genvar i = 0; i < N_WFLAG; i++) begin : g_wflag
         rtc_wflag_sync #(
            .SYNC_STAGES   (SYNC_STAGES),
            .FORCE_IN_INIT (i < 2)
         ) u_wf (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (ctrl_en_q[i]),
            .init_i (init_q),
            .wf_o   (wflag[i])
         );
      end

      for (genvar e = 0; e < N_EVT; e++) begin : g_evt
         rtc_evt_flag #(.CLR_LAT(CLR_LAT)) u_evt (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (evt_set[e]),
            .clr_wr_i (wr_stat && !bus_wdata[ST_EVT_LO + e]),
            .flag_o   (evt_flags[e])
         );
      end
   endgenerate

   rtc_shift_ctl #(.LAT(SHIFT_LAT), .AMT_W(SHIFT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (wr_shift && unlocked),
      .amt_i     (bus_wdata[SHIFT_W-1:0]),
      .pending_o (shift_pending),
      .strobe_o  (shift_strobe),
      .amt_o     (shift_amt)
   );

   always_comb begin
      rd_stat = '0;
      rd_stat[N_WFLAG-1:0]           = wflag;
      rd_stat[ST_SHIFT_PEND]         = shift_pending;
      rd_stat[ST_CAL_OK]             = |year_val;
      rd_stat[ST_UNLOCKED]           = unlocked;
      rd_stat[ST_INIT]               = init_q;
      rd_stat[ST_EVT_LO +: N_EVT]    = evt_flags;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL:  bus_rdata[N_WFLAG-1:0] = ctrl_en_q;
         OFS_STAT:  bus_rdata[ST_W-1:0]    = rd_stat;
         OFS_SHIFT: bus_rdata[SHIFT_W-1:0] = shift_amt;
         default:   bus_rdata = '0;
      endcase
   end

   assign alarm_a_en = ctrl_en_q[0];
   assign alarm_b_en = ctrl_en_q[1];
   assign wakeup_en  = ctrl_en_q[2];
   assign init_mode  = init_q;

   // R8: locked control writes leave the enables alone
   assert_locked_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !unlocked) |=> $stable(ctrl_en_q));

   // R8: locked status writes leave initialisation mode alone
   assert_locked_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !unlocked) |=> $stable(init_mode));
endmodule

// File: tb/tb_rtc_flag_ctrl.sv
`timescale 1ns/1ps
module tb_rtc_flag_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_enable = 1'b0, bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  year_val = '0;
   logic [3:0]  evt_set = '0;
   logic        alarm_a_en, alarm_b_en, wakeup_en, init_mode, shift_strobe;
   logic [3:0]  evt_flags;
   logic [14:0] shift_amt;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_KEY = 4'h8, A_SHIFT = 4'hC;

   always #10 clk = ~clk;

   rtc_flag_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .year_val(year_val), .evt_set(evt_set),
      .alarm_a_en(alarm_a_en), .alarm_b_en(alarm_b_en), .wakeup_en(wakeup_en),
      .init_mode(init_mode), .evt_flags(evt_flags), .shift_strobe(shift_strobe),
      .shift_amt(shift_amt)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; write lands on the next-but-one rising edge,
   // returns at the falling edge right after it
   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_enable = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      bus_addr = a;
      #2;
      v = bus_rdata;
   endtask

   task automatic unlock();
      bus_wr(A_KEY, 32'hCA);
      bus_wr(A_KEY, 32'h53);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_STAT, v); chk("R10 status in reset", v, 32'h0);
      rd(A_CTRL, v); chk("R10 control in reset", v, 32'h0);
      chk("R10 evt_flags in reset", {28'h0, evt_flags}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); rd(A_STAT, v); chk("R10 wflags one cycle after reset", v & 32'h7, 32'h0);
      @(negedge clk); rd(A_STAT, v); chk("R10 wflags two cycles after reset", v & 32'h7, 32'h7);
   endtask

   task automatic t_key();
      logic [31:0] v;
      bus_wr(A_KEY, 32'hCA);
      rd(A_STAT, v); chk("R9 half key stays locked", (v >> 5) & 1, 32'h0);
      bus_wr(A_KEY, 32'h53);
      rd(A_STAT, v); chk("R9 full key unlocks", (v >> 5) & 1, 32'h1);
      bus_wr(A_KEY, 32'h11);
      rd(A_STAT, v); chk("R9 wrong key relocks", (v >> 5) & 1, 32'h0);
      bus_wr(A_KEY, 32'hCA);
      bus_wr(A_CTRL, 32'h0);
      bus_wr(A_KEY, 32'h53);
      rd(A_STAT, v); chk("R9 interrupted sequence stays locked", (v >> 5) & 1, 32'h0);
   endtask

   task automatic t_locked();
      logic [31:0] v;
      bus_wr(A_CTRL, 32'h7);
      rd(A_CTRL, v); chk("R8 locked control write ignored", v, 32'h0);
      chk("R8 alarm_a_en stays low", {31'h0, alarm_a_en}, 32'h0);
      bus_wr(A_SHIFT, 32'h5);
      rd(A_STAT, v); chk("R8 locked shift write ignored", (v >> 3) & 1, 32'h0);
      bus_wr(A_STAT, 32'h0F80);
      rd(A_STAT, v); chk("R8 locked init write ignored", (v >> 7) & 1, 32'h0);
   endtask

   task automatic t_wflags();
      logic [31:0] v;
      unlock();
      bus_wr(A_CTRL, 32'h7);
      rd(A_CTRL, v); chk("R8 unlocked control write", v, 32'h7);
      @(negedge clk); rd(A_STAT, v); chk("R4 R5 flags fall after enable set", v & 7, 32'h0);
      bus_wr(A_CTRL, 32'h0);
      rd(A_STAT, v); chk("R5 flags low at clear edge", v & 7, 32'h0);
      @(negedge clk); rd(A_STAT, v); chk("R5 flags low one cycle after clear", v & 7, 32'h0);
      @(negedge clk); rd(A_STAT, v); chk("R5 flags rise two cycles after clear", v & 7, 32'h7);
      bus_wr(A_CTRL, 32'h7);
      @(negedge clk);
      bus_wr(A_CTRL, 32'h3);
      @(negedge clk);
      @(negedge clk); rd(A_STAT, v); chk("R4 only wakeup flag rises", v & 7, 32'h4);
      bus_wr(A_CTRL, 32'h0);
      @(negedge clk); @(negedge clk);
      rd(A_STAT, v); chk("R5 alarm flags back", v & 7, 32'h7);
   endtask

   task automatic t_init();
      logic [31:0] v;
      bus_wr(A_STAT, 32'h0F80);
      chk("R6 init mode entered", {31'h0, init_mode}, 32'h1);
      @(negedge clk); rd(A_STAT, v); chk("R6 alarm flags forced low", v & 7, 32'h4);
      bus_wr(A_STAT, 32'h0F00);
      @(negedge clk); rd(A_STAT, v); chk("R6 alarm flags return", v & 7, 32'h7);
   endtask

   task automatic t_events();
      logic [31:0] v;
      bus_wr(A_KEY, 32'h0);
      evt_set = 4'hF;
      @(negedge clk);
      evt_set = 4'h0;
      chk("R7 events set", {28'h0, evt_flags}, 32'hF);
      bus_wr(A_STAT, 32'h0E00);
      chk("R7 flag held at write edge", {28'h0, evt_flags}, 32'hF);
      @(negedge clk); chk("R7 flag held one cycle later", {28'h0, evt_flags}, 32'hF);
      @(negedge clk); chk("R7 R8 flag cleared after two cycles while locked",
                          {28'h0, evt_flags}, 32'hE);
      bus_wr(A_STAT, 32'h0F00);
      @(negedge clk); @(negedge clk); @(negedge clk);
      rd(A_STAT, v); chk("R7 writing ones has no effect", (v >> 8) & 32'hF, 32'hE);
      bus_wr(A_STAT, 32'h0);
      @(negedge clk); @(negedge clk);
      chk("R7 all flags cleared", {28'h0, evt_flags}, 32'h0);
   endtask

   task automatic t_shift();
      logic [31:0] v;
      unlock();
      bus_wr(A_STAT, 32'h0F08);
      @(negedge clk); rd(A_STAT, v); chk("R3 write one to pending ignored", (v >> 3) & 1, 32'h0);
      bus_wr(A_SHIFT, 32'h1234);
      rd(A_STAT, v); chk("R2 pending after write", (v >> 3) & 1, 32'h1);
      chk("R2 no strobe yet", {31'h0, shift_strobe}, 32'h0);
      bus_wr(A_STAT, 32'h0F00);
      rd(A_STAT, v); chk("R3 write zero to pending ignored", (v >> 3) & 1, 32'h1);
      chk("R2 strobe in last cycle", {31'h0, shift_strobe}, 32'h1);
      chk("R2 shift amount", {17'h0, shift_amt}, 32'h1234);
      @(negedge clk); rd(A_STAT, v); chk("R2 pending cleared", (v >> 3) & 1, 32'h0);
   endtask

   task automatic t_cal();
      logic [31:0] v;
      rd(A_STAT, v); chk("R1 year zero", (v >> 4) & 1, 32'h0);
      year_val = 8'd24;
      rd(A_STAT, v); chk("R1 year non-zero", (v >> 4) & 1, 32'h1);
      year_val = 8'd0;
      rd(A_STAT, v); chk("R1 year back to zero", (v >> 4) & 1, 32'h0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_key();
      t_locked();
      t_wflags();
      t_init();
      t_events();
      t_shift();
      t_cal();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule